// File: doc/BRIEF.md
# Isolation Link Supervisor with No-Transition Watchdog

This block watches a serial link that crosses an isolation barrier between a host-side and a line-side device. It takes two asynchronous inputs: a level that reports whether the link is synchronized, and the barrier data line, which toggles while the link is alive. Both pass through a synchronizer chain of `SYNC_STAGES` flops before any logic uses them.

The host sees three small registers through a plain read/write port. A control register holds the sync-loss interrupt mask, the auto-poll enable and the watchdog disable. A status register holds two clear-on-read flags. The first is a sticky loss flag that is set when synchronization drops and drives a maskable interrupt. The second is a "not synchronized" bit that comes out of reset set and re-arms every cycle while the loss persists. The third register holds the identifier of the remote device. The supervisor asks for a fresh identifier each time the link synchronizes, and wipes it to zero while the link is down.

A no-transition watchdog counts system clocks since the last edge of the barrier data line. When it reaches a limit equal to `WD_US` microseconds at `CLK_KHZ`, it emits a one-cycle pulse that resets the line-side logic and takes the line on hook.

Top module: `iso_link_supervisor`

## Requirements
- R1: After reset, control reads 3 (bit0 interrupt mask = 1, bit1 auto-poll = 1, bit2 watchdog off = 0), status reads 2 (bit0 loss flag = 0, bit1 not-synchronized = 1), the identifier reads 0, and irq and poll_req are low.
- R2: A falling edge of link_sync sets status bit0 on the clock edge `SYNC_STAGES` cycles after the edge that samples the fall. A read of status (address 1, reg_rd = 1) clears it, except when the set happens on the same edge, in which case the bit stays 1.
- R3: irq is high exactly while status bit0 is 1 and control bit0 is 1. It falls right after the clearing read.
- R4: Status bit1 is cleared by a status read. If link_sync is still low, it reads 1 again one cycle later. While the link is synchronized it stays 0 after the read.
- R5: On each rising edge of link_sync, poll_req pulses high for exactly one cycle, `SYNC_STAGES` cycles after the sampling edge, when control bit1 is 1. When control bit1 is 0 there is no pulse.
- R6: While the link is synchronized, an id_load strobe stores id_in, which is then readable at address 2. The stored identifier becomes 0 `SYNC_STAGES` cycles after link_sync falls, and id_load has no effect while the link is down.
- R7: With control bit2 = 0, hook_rst pulses for one cycle once `CLK_KHZ*WD_US/1000` cycles pass with no edge on bar_line. A toggle of bar_line in either direction restarts the count, and the pulse also restarts it, so it repeats every limit while the line stays quiet.
- R8: With control bit2 = 1, hook_rst never pulses and the count is held at zero.
- R9: Writing address 0 updates control bits [2:0]. Control holds its value without a write. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_sync | input | 1 | Asynchronous barrier-synchronized level |
| bar_line | input | 1 | Asynchronous barrier data line watched for edges |
| id_load | input | 1 | Strobe that stores a polled remote identifier |
| id_in | input | ID_W | Remote identifier value |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on address 1) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Masked sync-loss interrupt |
| poll_req | output | 1 | One-cycle request to poll the remote identifier |
| hook_rst | output | 1 | One-cycle line-side reset and on-hook command |

## Verification
Every link result lags its stimulus by the synchronizer depth. The loss flag, interrupt, poll pulse and identifier wipe all appear on the edge `SYNC_STAGES` after the edge that samples the change. The bench drives inputs on falling edges and steps through a window of falling edges, and it expects each change at that exact index and at no other. Register reads return data combinationally, and their clearing effect is checked on the falling edge right after the strobed edge. The watchdog pulse is expected at the limit plus the synchronizer depth plus one, counted from the toggle, and then again one limit later. The same window rule applies, which checks both the restart and the re-arm.

// File: rtl/iso_sup_pkg.sv
package iso_sup_pkg;
   localparam int unsigned ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
   localparam logic [ADDR_W-1:0] A_STAT  = 2'd1;
   localparam logic [ADDR_W-1:0] A_DEVID = 2'd2;

   typedef struct packed {
      logic wd_off;   // bit2
      logic poll_en;  // bit1
      logic irq_en;   // bit0
   } ctrl_t;

   localparam ctrl_t CTRL_RST = '{wd_off: 1'b0, poll_en: 1'b1, irq_en: 1'b1};
endpackage

// File: rtl/iso_sync_chain.sv
module iso_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] stg;

   generate
      if (STAGES < 1) begin : g_bad
         $error("iso_sync_chain: STAGES must be at least 1");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_st
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= 1'b0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[g] <= 1'b0;
               else        stg[g] <= stg[g-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/iso_link_monitor.sv
module iso_link_monitor #(
   parameter int unsigned ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sync_s,
   input  logic            poll_en,
   input  logic            irq_en,
   input  logic            stat_rd,
   input  logic            id_load,
   input  logic [ID_W-1:0] id_in,
   output logic            loss_flag,
   output logic            unsync_flag,
   output logic            poll_req,
   output logic [ID_W-1:0] dev_id,
   output logic            irq
);
   logic sync_prev;
   logic loss_evt;
   logic sync_rise;

   assign loss_evt  = sync_prev & ~sync_s;
   assign sync_rise = ~sync_prev & sync_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_prev   <= 1'b0;
         loss_flag   <= 1'b0;
         unsync_flag <= 1'b1;
         poll_req    <= 1'b0;
         dev_id      <= '0;
      end else begin
         sync_prev <= sync_s;
         // sticky flag: a new loss outranks a clearing read
         if (loss_evt)     loss_flag <= 1'b1;
         else if (stat_rd) loss_flag <= 1'b0;
         // level flag: read clears, persisting loss re-arms next cycle
         if (stat_rd)      unsync_flag <= 1'b0;
         else if (!sync_s) unsync_flag <= 1'b1;
         poll_req <= sync_rise & poll_en;
         if (!sync_s)      dev_id <= '0;
         else if (id_load) dev_id <= id_in;
      end
   end

   assign irq = loss_flag & irq_en;

   AST_LOSS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      loss_evt |=> loss_flag); // R2
   AST_LOSS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !loss_evt) |=> !loss_flag); // R2
   AST_UNSYNC_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_s && !stat_rd) |=> unsync_flag); // R4
   AST_POLL_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      poll_req |-> (sync_prev && !$past(sync_prev) && $past(poll_en))); // R5
   AST_ID_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_s |=> (dev_id == '0)); // R6
endmodule

// File: rtl/iso_watchdog.sv
module iso_watchdog #(
   parameter int unsigned WD_CYCLES = 80000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_s,
   input  logic wd_off,
   output logic hook_rst
);
   localparam int unsigned CNT_W = $clog2(WD_CYCLES + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WD_CYCLES - 1);

   generate
      if (WD_CYCLES < 2) begin : g_bad
         $error("iso_watchdog: WD_CYCLES must be at least 2");
      end
   endgenerate

   logic             line_prev;
   logic             line_edge;
   logic [CNT_W-1:0] cnt;
   logic             expire;

   assign line_edge = line_s ^ line_prev;
   assign expire    = (cnt == LAST) & ~line_edge & ~wd_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_prev <= 1'b0;
         cnt       <= '0;
         hook_rst  <= 1'b0;
      end else begin
         line_prev <= line_s;
         hook_rst  <= expire;
         if (line_edge || wd_off || cnt == LAST) cnt <= '0;
         else                                    cnt <= cnt + 1'b1;
      end
   end

   AST_HOOK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      hook_rst |=> !hook_rst); // R7
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST); // R7
   AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      line_edge |=> (cnt == '0 && !hook_rst)); // R7
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      wd_off |=> (!hook_rst && cnt == '0)); // R8
endmodule

// File: rtl/iso_link_supervisor.sv
module iso_link_supervisor
   import iso_sup_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ID_W        = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLK_KHZ     = 200000,
   parameter int unsigned WD_US       = 400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_sync,
   input  logic              bar_line,
   input  logic              id_load,
   input  logic [ID_W-1:0]   id_in,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              poll_req,
   output logic              hook_rst
);
   localparam int unsigned WD_CYCLES = CLK_KHZ * WD_US / 1000;

   generate
      if (DATA_W < 4 || ID_W > DATA_W || ID_W < 1) begin : g_bad_w
         $error("iso_link_supervisor: DATA_W must be >= 4 and >= ID_W");
      end
   endgenerate

   logic            sync_s;
   logic            line_s;
   ctrl_t           ctrl;
   logic            stat_rd;
   logic            ctrl_wr;
   logic            loss_flag;
   logic            unsync_flag;
   logic [ID_W-1:0] dev_id;
   logic            unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-1:3];

   iso_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_link (
      .clk(clk), .rst_n(rst_n), .d(link_sync), .q(sync_s));

   iso_sync_chain #(.STAGES(SYNC_STAGES)) u_sync_line (
      .clk(clk), .rst_n(rst_n), .d(bar_line), .q(line_s));

   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
   assign stat_rd = reg_rd && (reg_addr == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl <= CTRL_RST;
      else if (ctrl_wr) ctrl <= ctrl_t'(reg_wdata[2:0]);
   end

   iso_link_monitor #(.ID_W(ID_W)) u_mon (
      .clk(clk), .rst_n(rst_n), .sync_s(sync_s),
      .poll_en(ctrl.poll_en), .irq_en(ctrl.irq_en), .stat_rd(stat_rd),
      .id_load(id_load), .id_in(id_in),
      .loss_flag(loss_flag), .unsync_flag(unsync_flag),
      .poll_req(poll_req), .dev_id(dev_id), .irq(irq));

   iso_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
      .clk(clk), .rst_n(rst_n), .line_s(line_s),
      .wd_off(ctrl.wd_off), .hook_rst(hook_rst));

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata[2:0]      = ctrl;
         A_STAT:  reg_rdata[1:0]      = {unsync_flag, loss_flag};
         A_DEVID: reg_rdata[ID_W-1:0] = dev_id;
         default: reg_rdata           = '0;
      endcase
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(ctrl)); // R9
   AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (ctrl == $past(reg_wdata[2:0]))); // R9
endmodule

// File: tb/iso_link_supervisor_tb.sv
module iso_link_supervisor_tb;
   localparam int S  = 2;
   localparam int WD = 100 * 400 / 1000; // 40 cycles

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       link_sync = 1'b0, bar_line = 1'b0, id_load = 1'b0;
   logic [3:0] id_in = '0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq, poll_req, hook_rst;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   iso_link_supervisor #(.DATA_W(8), .ID_W(4), .SYNC_STAGES(S),
                         .CLK_KHZ(100), .WD_US(400)) u_dut (
      .clk(clk), .rst_n(rst_n), .link_sync(link_sync), .bar_line(bar_line),
      .id_load(id_load), .id_in(id_in), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .poll_req(poll_req),
      .hook_rst(hook_rst));

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      reg_addr = a;
      #1 v = int'(reg_rdata);
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = int'(reg_rdata);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic load_id(input logic [3:0] v);
      @(negedge clk);
      id_in = v; id_load = 1'b1;
      @(negedge clk);
      id_load = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      peek(2'd0, v); chk(v, 3, "R1 ctrl reset");
      peek(2'd1, v); chk(v, 2, "R1 status reset");
      peek(2'd2, v); chk(v, 0, "R1 id reset");
      chk(int'(irq), 0, "R1 irq reset");
      chk(int'(poll_req), 0, "R1 poll reset");
      peek(2'd3, v); chk(v, 0, "R9 unused address");

      // sweep of interrupt mask and auto-poll
      for (int cfg = 0; cfg < 4; cfg++) begin
         logic ie, pe;
         logic [3:0] idv;
         ie = cfg[0]; pe = cfg[1];
         idv = 4'(cfg * 5 + 3);
         wr(2'd0, {5'b0, 1'b1, pe, ie});
         peek(2'd0, v); chk(v, 4 + cfg, "R9 ctrl write");
         @(negedge clk); link_sync = 1'b1;
         for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk(int'(poll_req), int'(i == S + 1 && pe), "R5 poll pulse");
         end
         rd(2'd1, v);
         peek(2'd1, v); chk(v, 0, "R4 read clears when synced");
         @(negedge clk);
         peek(2'd1, v); chk(v, 0, "R4 stays clear when synced");
         load_id(idv);
         peek(2'd2, v); chk(v, int'(idv), "R6 id load");
         peek(2'd0, v); chk(v, 4 + cfg, "R9 ctrl holds");
         reg_addr = 2'd2;
         link_sync = 1'b0;
         for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            #1;
            chk(int'(irq), int'(i >= S + 1 && ie), "R3 irq after loss");
            chk(int'(reg_rdata), (i >= S + 1) ? 0 : int'(idv), "R6 id wipe");
         end
         peek(2'd1, v); chk(v, 3, "R2 loss flag set");
         load_id(4'hF);
         peek(2'd2, v); chk(v, 0, "R6 load ignored while down");
         rd(2'd1, v); chk(v, 3, "R2 status read value");
         peek(2'd1, v); chk(v, 0, "R2 R4 cleared by read");
         chk(int'(irq), 0, "R3 irq drops after read");
         @(negedge clk);
         peek(2'd1, v); chk(v, 2, "R4 re-arms while lost");
      end

      // R2 set beats a simultaneous read
      @(negedge clk); link_sync = 1'b1;
      repeat (5) @(negedge clk);
      rd(2'd1, v);
      link_sync = 1'b0;
      @(negedge clk);
      rd(2'd1, v); chk(v & 1, 0, "R2 flag before set");
      peek(2'd1, v); chk(v & 1, 1, "R2 set wins over read");

      // R6 exhaustive id loads
      @(negedge clk); link_sync = 1'b1;
      repeat (5) @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         load_id(4'(k));
         peek(2'd2, v); chk(v, k, "R6 id value");
      end

      // R7 watchdog restart on either edge direction and re-arm
      for (int t = 0; t < 2; t++) begin
         wr(2'd0, 8'h07);
         wr(2'd0, 8'h03);
         bar_line = ~bar_line;
         for (int i = 1; i <= 2 * WD + S + 3; i++) begin
            @(negedge clk);
            chk(int'(hook_rst),
                int'(i == WD + S + 1 || i == 2 * WD + S + 1), "R7 hook timing");
         end
      end

      // R8 disabled watchdog never fires
      wr(2'd0, 8'h07);
      for (int i = 1; i <= 3 * WD; i++) begin
         @(negedge clk);
         chk(int'(hook_rst), 0, "R8 hook while disabled");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule